// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes a stream of instruction bytes, one per accepted transfer, and turns each instruction into one decoded record. The instruction set has three encodings, one, two and three bytes long. The leading bits of the first byte choose the encoding and so fix how many further bytes the decoder must gather. Bytes arrive most-significant byte first.

Once the last byte of an instruction has been taken, the decoder presents one record on its output. The record holds a format tag, a flat opcode index from 0 to 39, the register fields and a 16-bit immediate. A valid/ready handshake paces both the byte input and the record output. While a record waits to be taken, the input stays not-ready, so a slow consumer stalls the byte source. Opcodes that no instruction uses are still decoded and reported like any other.

Top module: `vld_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `out_valid` is 0 and `in_ready` is 1. The decoder then treats the next accepted byte as the first byte of an instruction.
- R2: A first byte with bit 7 set is a complete one-byte instruction. It produces format code 0, opcode index = bits 6:4, `out_rd` = bits 3:2, `out_rs` = bits 1:0 and `out_imm` = 0.
- R3: A first byte with bits 7:6 = 00 starts a two-byte instruction. It produces format code 1, opcode index = 8 + bits 5:2, `out_rd` = bits 1:0, `out_rs` = 0, and `out_imm` holds the second byte in bits 7:0 with bits 15:8 at zero.
- R4: A first byte with bits 7:6 = 01 starts a three-byte instruction. It produces format code 2, opcode index = 24 + bits 5:2, `out_rd` = bits 1:0, `out_rs` = 0, and `out_imm` = {second byte, third byte}.
- R5: `out_valid` rises in the cycle after the final byte of an instruction is accepted, and not before. Each instruction yields exactly one record.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every record field stays unchanged.
- R7: `in_ready` is 0 whenever `out_valid` is 1. A byte offered in that time is not consumed and has no effect on later records.
- R8: Idle cycles with `in_valid` low, before or between the bytes of an instruction, leave the decoded result unchanged. No record appears during them.
- R9: After a cycle with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.
- R10: A reset in the middle of an instruction discards the bytes already gathered. The next accepted byte is decoded as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte source has a byte |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction byte, most-significant byte first |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_fmt | output | 2 | Format code: 0 one-byte, 1 two-byte, 2 three-byte |
| out_opidx | output | 6 | Flat opcode index 0..39 |
| out_rd | output | 2 | First register field |
| out_rs | output | 2 | Second register field (one-byte format only, else 0) |
| out_imm | output | 16 | Zero-extended literal or address |

## Verification
The assertions assume that the byte source follows the handshake: a byte counts only in a cycle where `in_valid` and `in_ready` are both high. They also assume that the reset is held for at least one clock edge before any traffic starts. The stimulus drives and releases every input at the falling edge, so each byte or record acceptance lands on exactly one rising edge. The bench offers bytes only through that handshake, except in the one test that deliberately offers a byte while `in_ready` is low.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int BYTE_W      = 8;
    localparam int REG_W       = 2;
    localparam int IMM_W       = 16;
    localparam int OPIDX_W     = 6;
    localparam int SHORT_OPS   = 8;
    localparam int WIDE_OPS    = 16;
    localparam int MEDIUM_BASE = SHORT_OPS;
    localparam int LONG_BASE   = SHORT_OPS + WIDE_OPS;
    localparam int TOTAL_OPS   = LONG_BASE + WIDE_OPS;
    localparam int SUBOP_W     = $clog2(WIDE_OPS);
    localparam int SHOP_W      = $clog2(SHORT_OPS);

    typedef enum logic [1:0] {
        FMT_SHORT  = 2'd0,
        FMT_MEDIUM = 2'd1,
        FMT_LONG   = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_THIRD  = 2'd2
    } gather_e;

    typedef struct packed {
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
    } raw_t;

    typedef struct packed {
        fmt_e               fmt;
        logic [OPIDX_W-1:0] opidx;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs;
        logic [IMM_W-1:0]   imm;
    } rec_t;

    function automatic fmt_e fmt_of(input logic [BYTE_W-1:0] lead);
        if (lead[BYTE_W-1])      return FMT_SHORT;
        else if (lead[BYTE_W-2]) return FMT_LONG;
        else                     return FMT_MEDIUM;
    endfunction

endpackage

// File: rtl/vld_gather.sv
module vld_gather
    import vld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic              done,
    output raw_t              raw
);

    gather_e           state_q;
    fmt_e              fmt_q;
    logic [BYTE_W-1:0] b0_q;
    logic [BYTE_W-1:0] b1_q;
    fmt_e              lead_fmt;

    assign lead_fmt = fmt_of(din);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FIRST;
            fmt_q   <= FMT_SHORT;
            b0_q    <= '0;
            b1_q    <= '0;
        end else if (take) begin
            unique case (state_q)
                ST_FIRST: begin
                    b0_q  <= din;
                    fmt_q <= lead_fmt;
                    if (lead_fmt != FMT_SHORT) state_q <= ST_SECOND;
                end
                ST_SECOND: begin
                    b1_q    <= din;
                    state_q <= (fmt_q == FMT_LONG) ? ST_THIRD : ST_FIRST;
                end
                ST_THIRD: state_q <= ST_FIRST;
                default:  state_q <= ST_FIRST;
            endcase
        end
    end

    always_comb begin
        done = 1'b0;
        raw  = '0;
        if (take) begin
            unique case (state_q)
                ST_FIRST: begin
                    done   = (lead_fmt == FMT_SHORT);
                    raw.b0 = din;
                end
                ST_SECOND: begin
                    done   = (fmt_q == FMT_MEDIUM);
                    raw.b0 = b0_q;
                    raw.b1 = din;
                end
                ST_THIRD: begin
                    done   = 1'b1;
                    raw.b0 = b0_q;
                    raw.b1 = b1_q;
                    raw.b2 = din;
                end
                default: done = 1'b0;
            endcase
        end
    end

    // R4: the third-byte state is only ever entered for the long format
    a_r4_third_only_long: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_THIRD) |-> (fmt_q == FMT_LONG));

    // R3: a medium instruction never reaches the third-byte state
    a_r3_medium_two_bytes: assert property (@(posedge clk) disable iff (rst)
        (take && state_q == ST_SECOND && fmt_q == FMT_MEDIUM) |=> (state_q == ST_FIRST));

endmodule

// File: rtl/vld_fields.sv
module vld_fields
    import vld_pkg::*;
(
    input  raw_t raw,
    output rec_t rec
);

    fmt_e               fmt;
    logic [SUBOP_W-1:0] subop;
    logic [SHOP_W-1:0]  shop;

    assign fmt   = fmt_of(raw.b0);
    assign subop = raw.b0[REG_W +: SUBOP_W];
    assign shop  = raw.b0[2*REG_W +: SHOP_W];

    always_comb begin
        rec     = '0;
        rec.fmt = fmt;
        unique case (fmt)
            FMT_SHORT: begin
                rec.opidx = OPIDX_W'(shop);
                rec.rd    = raw.b0[REG_W +: REG_W];
                rec.rs    = raw.b0[0 +: REG_W];
            end
            FMT_MEDIUM: begin
                rec.opidx = OPIDX_W'(MEDIUM_BASE) + OPIDX_W'(subop);
                rec.rd    = raw.b0[0 +: REG_W];
                rec.imm   = IMM_W'(raw.b1);
            end
            FMT_LONG: begin
                rec.opidx = OPIDX_W'(LONG_BASE) + OPIDX_W'(subop);
                rec.rd    = raw.b0[0 +: REG_W];
                rec.imm   = {raw.b1, raw.b2};
            end
            default: rec = '0;
        endcase
    end

endmodule

// File: rtl/vld_outreg.sv
module vld_outreg
    import vld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  rec_t rec_in,
    input  logic pop,
    output logic valid,
    output rec_t rec_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            rec_out <= '0;
        end else if (load) begin
            valid   <= 1'b1;
            rec_out <= rec_in;
        end else if (pop) begin
            valid   <= 1'b0;
        end
    end

    // R6: a pending record is held intact until taken
    a_r6_hold_record: assert property (@(posedge clk) disable iff (rst)
        (valid && !pop) |=> (valid && $stable(rec_out)));

    // R9: a taken record is released
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (valid && pop && !load) |=> !valid);

endmodule

// File: rtl/vld_decoder.sv
module vld_decoder
    import vld_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [1:0]          out_fmt,
    output logic [OPIDX_W-1:0]  out_opidx,
    output logic [REG_W-1:0]    out_rd,
    output logic [REG_W-1:0]    out_rs,
    output logic [IMM_W-1:0]    out_imm
);

    logic take;
    logic done;
    raw_t raw;
    rec_t rec_d;
    rec_t rec_q;

    assign in_ready = !out_valid;
    assign take     = in_valid && in_ready;

    vld_gather u_gather (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .din  (in_byte),
        .done (done),
        .raw  (raw)
    );

    vld_fields u_fields (
        .raw (raw),
        .rec (rec_d)
    );

    vld_outreg u_outreg (
        .clk     (clk),
        .rst     (rst),
        .load    (done),
        .rec_in  (rec_d),
        .pop     (out_ready),
        .valid   (out_valid),
        .rec_out (rec_q)
    );

    assign out_fmt   = rec_q.fmt;
    assign out_opidx = rec_q.opidx;
    assign out_rd    = rec_q.rd;
    assign out_rs    = rec_q.rs;
    assign out_imm   = rec_q.imm;

    // R5: the final byte produces a record on the next cycle
    a_r5_record_follows: assert property (@(posedge clk) disable iff (rst)
        done |=> out_valid);

    // R2: one-byte records carry no literal and a low opcode index
    a_r2_short_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fmt == FMT_SHORT) |-> (out_imm == '0 && out_opidx < OPIDX_W'(MEDIUM_BASE)));

    // R3: two-byte records carry a zero-extended byte literal
    a_r3_medium_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fmt == FMT_MEDIUM) |-> (out_imm[IMM_W-1:BYTE_W] == '0 && out_rs == '0
            && out_opidx >= OPIDX_W'(MEDIUM_BASE) && out_opidx < OPIDX_W'(LONG_BASE)));

    // R4: three-byte records index the top opcode range
    a_r4_long_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fmt == FMT_LONG) |-> (out_rs == '0
            && out_opidx >= OPIDX_W'(LONG_BASE) && out_opidx < OPIDX_W'(TOTAL_OPS)));

    // R7: nothing is consumed while a record waits
    a_r7_no_new_record: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_opidx));

endmodule

// File: tb/vld_decoder_tb_top.sv
`timescale 1ns/1ps
module vld_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_fmt;
    logic [5:0]  out_opidx;
    logic [1:0]  out_rd;
    logic [1:0]  out_rs;
    logic [15:0] out_imm;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vld_decoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_fmt   (out_fmt),
        .out_opidx (out_opidx),
        .out_rd    (out_rd),
        .out_rs    (out_rs),
        .out_imm   (out_imm)
    );

    // vector: {b0, b1, b2, fmt, opidx, rd, rs, imm}
    localparam int NV = 10;
    localparam logic [51:0] VEC [NV] = '{
        {8'hF6, 8'h00, 8'h00, 2'd0, 6'd7,  2'd1, 2'd2, 16'h0000},
        {8'h80, 8'h00, 8'h00, 2'd0, 6'd0,  2'd0, 2'd0, 16'h0000},
        {8'hAB, 8'h00, 8'h00, 2'd0, 6'd2,  2'd2, 2'd3, 16'h0000},
        {8'h00, 8'h5A, 8'h00, 2'd1, 6'd8,  2'd0, 2'd0, 16'h005A},
        {8'h3F, 8'hFF, 8'h00, 2'd1, 6'd23, 2'd3, 2'd0, 16'h00FF},
        {8'h16, 8'h0C, 8'h00, 2'd1, 6'd13, 2'd2, 2'd0, 16'h000C},
        {8'h40, 8'h13, 8'h88, 2'd2, 6'd24, 2'd0, 2'd0, 16'h1388},
        {8'h7F, 8'hFF, 8'hFF, 2'd2, 6'd39, 2'd3, 2'd0, 16'hFFFF},
        {8'h69, 8'h80, 8'h01, 2'd2, 6'd34, 2'd1, 2'd0, 16'h8001},
        {8'hC5, 8'h00, 8'h00, 2'd0, 6'd4,  2'd1, 2'd1, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_rec(input string req, input logic [51:0] v);
        chk(out_valid === 1'b1, {req, " valid"}, 32'(out_valid), 32'd1);
        chk(out_fmt === v[27:26], {req, " fmt"}, 32'(out_fmt), 32'(v[27:26]));
        chk(out_opidx === v[25:20], {req, " opidx"}, 32'(out_opidx), 32'(v[25:20]));
        chk(out_rd === v[19:18], {req, " rd"}, 32'(out_rd), 32'(v[19:18]));
        chk(out_rs === v[17:16], {req, " rs"}, 32'(out_rs), 32'(v[17:16]));
        chk(out_imm === v[15:0], {req, " imm"}, 32'(out_imm), 32'(v[15:0]));
    endtask

    task automatic take_rec();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 release", {30'd0, out_valid, in_ready}, 32'd1);
    endtask

    task automatic run_vec(input logic [51:0] v, input int gap);
        int nb;
        string req;
        nb  = (v[27:26] == 2'd0) ? 1 : (v[27:26] == 2'd1) ? 2 : 3;
        req = (nb == 1) ? "R2" : (nb == 2) ? "R3" : "R4";
        for (int i = 0; i < nb; i++) begin
            push(v[51 - 8*i -: 8]);
            if (i < nb - 1) begin
                chk(out_valid === 1'b0, "R5 early record", 32'(out_valid), 32'd0);
                if (gap > 0) begin
                    idle(gap);
                    chk(out_valid === 1'b0, "R8 record during gap", 32'(out_valid), 32'd0);
                end
            end
        end
        check_rec(req, v);
        take_rec();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
        chk(in_ready === 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);
        rst = 1'b0;
        idle(1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);

        // R8: idle gaps between bytes of a long instruction
        run_vec(VEC[8], 3);
        run_vec(VEC[4], 2);

        // R6: record held while consumer stalls
        push(8'hAB);
        for (int i = 0; i < 3; i++) begin
            idle(1);
            check_rec("R6 hold", VEC[2]);
        end
        // R7: byte offered while pending is ignored
        chk(in_ready === 1'b0, "R7 ready while pending", 32'(in_ready), 32'd0);
        push(8'h00);
        check_rec("R7 pending record", VEC[2]);
        take_rec();
        push(8'hF6);
        check_rec("R7 next decode", VEC[0]);
        take_rec();

        // R10: reset in the middle of a long instruction
        push(8'h40);
        push(8'h12);
        rst = 1'b1;
        idle(1);
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset state", {30'd0, out_valid, in_ready}, 32'd1);
        rst = 1'b0;
        push(8'h80);
        check_rec("R10 fresh decode", VEC[1]);
        take_rec();

        finish_run();
    end

endmodule